// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an external 64K x 16 asynchronous static RAM whose control strobes are all active low. The host issues a one-cycle request that carries a direction, a word address, write data and a per-byte lane mask. The controller then runs one read or write cycle on the memory pins, holding the strobes for a number of clock cycles that is derived from the clock period. It finishes by pulsing `host_done` for one cycle. For reads, the captured word appears on `host_rdata` in that same cycle.

The memory data bus is split into an outgoing word, a drive-enable for it and an incoming word, so the pad ring can build the bidirectional pins. The controller drives the bus only around the write pulse. When no access is running, chip select is held high so the memory stays in standby. A request whose lane mask is all zero is finished at once and never touches the memory.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, the outputs are as follows. `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, and every bit of `mem_be_n` is 1. `mem_dout_en`, `host_done` and `host_rdata` are 0.
- R2: When no access is in progress, the outputs are as follows. `mem_cs_n` is 1, `mem_oe_n` and `mem_we_n` are 1, every bit of `mem_be_n` is 1, and `mem_dout_en` is 0.
- R3: A read is a request with `host_wr`=0 and a nonzero mask, taken while idle. For RD_CLKS cycles, starting in the cycle after acceptance, `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dout_en`=0. Mask bit g set to 1 enables byte lane g, where lane 0 is data bits 7:0 and lane 1 is bits 15:8. `mem_be_n[g]` is the inverse of that mask bit.
- R4: On the last cycle of the read window, `host_rdata` is loaded from `mem_din`. Each enabled lane takes the memory byte and each disabled lane reads as 0. At all other times `host_rdata` keeps its value.
- R5: A write is a request with `host_wr`=1 and a nonzero mask, taken while idle. For WP_CLKS cycles after acceptance, `mem_cs_n`=0, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dout_en`=1. During those cycles `mem_dout` equals the request data and `mem_be_n` is set from the mask as in R3.
- R6: After the write pulse there is exactly one hold cycle. In it, `mem_we_n`=1, `mem_cs_n`=0, `mem_dout_en`=1, and the data, address and lane enables are unchanged. `mem_dout_en` is never 1 while `mem_oe_n` is 0.
- R7: `host_done` is 1 for one cycle per accepted access. For a read it comes in the cycle after the last read cycle, and for a write in the cycle after the hold cycle. In that cycle the memory is idle.
- R8: A request with an all-zero mask raises `host_done` in the next cycle, and `mem_cs_n` stays 1.
- R9: Requests presented while an access is in progress are ignored.
- R10: `mem_addr` holds the accepted address, unchanged for the whole time `mem_cs_n` is low.
- R11: RD_CLKS is CYCLE_NS divided by CLK_PERIOD_NS, rounded up. WP_CLKS is WPULSE_NS divided by CLK_PERIOD_NS, rounded up. Both are at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request, sampled only while idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Word address |
| host_wdata | input | DW | Write data |
| host_mask | input | DW/8 | Lane enables, bit g = byte lane g |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Captured read word |
| mem_addr | output | AW | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DW/8 | Byte-lane enables, active low |
| mem_dout | output | DW | Data toward the memory |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | DW | Data from the memory |

## Verification
The hardest situation to reach is a read that follows a write with no spare time in between. Only there can the controller's drive window and the memory's output window come close to meeting. The stimulus gets there by raising the next request in the very cycle `host_done` appears. A second hard case is a request held high through a busy access with a different address and direction, which must be ignored. The bench reaches it by keeping that noise on the request lines until completion. Partial-lane writes that overlay earlier data are read back under every mask. This shows that untouched lanes keep their old value and that disabled read lanes come back as zero.

// File: rtl/sram_lane_pkg.sv
// Shared types and helpers for the SRAM byte-lane controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sram_lane_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_HOLD  = 2'd3
    } acc_state_e;

    // Number of clock cycles covering ns, rounded up, never below one.
    function automatic int unsigned ceil_clks(input int unsigned ns, input int unsigned period);
        int unsigned q;
        q = (ns + period - 1) / period;
        return (q == 0) ? 1 : q;
    endfunction

endpackage

// File: rtl/sram_wait_ctr.sv
// Down-counter that times one strobe window.
// Assumes: load and dec are never high together; expired is high at zero.
module sram_wait_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load at acceptance, then count down once per window cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= cnt - W'(1);
    end

    // Window ends when the count reaches zero.
    always_comb expired = (cnt == '0);
endmodule

// File: rtl/sram_lane_fsm.sv
// Access sequencer: idle, read window, write pulse, write hold.
// Assumes: requests are looked at only in idle; zero-mask requests finish at once.
module sram_lane_fsm
    import sram_lane_pkg::*;
#(
    parameter int RD_CLKS = 2,
    parameter int WP_CLKS = 2,
    parameter int CW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic          mask_any,
    input  logic          expired,
    output acc_state_e    state,
    output logic          accept,
    output logic          ld,
    output logic [CW-1:0] ld_val,
    output logic          dec,
    output logic          capture,
    output logic          done
);
    // Decode the counter controls and the read capture from the state.
    always_comb begin
        accept  = (state == ACC_IDLE) && req && mask_any;
        ld      = accept;
        ld_val  = wr ? CW'(WP_CLKS - 1) : CW'(RD_CLKS - 1);
        dec     = ((state == ACC_READ) || (state == ACC_WRITE)) && !expired;
        capture = (state == ACC_READ) && expired;
    end

    // Step the state and raise the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ACC_IDLE;
            done  <= 1'b0;
        end else begin
            done <= ((state == ACC_IDLE) && req && !mask_any) || capture || (state == ACC_HOLD);
            unique case (state)
                ACC_IDLE:  if (accept)  state <= wr ? ACC_WRITE : ACC_READ;
                ACC_READ:  if (expired) state <= ACC_IDLE;
                ACC_WRITE: if (expired) state <= ACC_HOLD;
                ACC_HOLD:  state <= ACC_IDLE;
                default:   state <= ACC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sram_lane_datapath.sv
// Holds the accepted address, data and mask; captures read data per lane.
// Assumes: DW is a multiple of 8; disabled lanes read back as zero.
module sram_lane_datapath #(
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             capture,
    input  logic [AW-1:0]    host_addr,
    input  logic [DW-1:0]    host_wdata,
    input  logic [LANES-1:0] host_mask,
    input  logic [DW-1:0]    mem_din,
    output logic [AW-1:0]    addr_q,
    output logic [DW-1:0]    wdata_q,
    output logic [LANES-1:0] mask_q,
    output logic [DW-1:0]    rdata
);
    // Latch the request fields when an access starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            mask_q  <= host_mask;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Capture one byte lane at the end of the read window.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata[8*g +: 8] <= '0;
            else if (capture)
                rdata[8*g +: 8] <= mask_q[g] ? mem_din[8*g +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
// Top: turns single-cycle host requests into asynchronous SRAM cycles.
// Assumes: the memory meets its access within CYCLE_NS and needs a write
// pulse of WPULSE_NS; address setup and hold of zero; pads are outside.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int AW            = 16,
    parameter int DW            = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int CYCLE_NS      = 15,
    parameter int WPULSE_NS     = 12,
    localparam int LANES        = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_wr,
    input  logic [AW-1:0]    host_addr,
    input  logic [DW-1:0]    host_wdata,
    input  logic [LANES-1:0] host_mask,
    output logic             host_done,
    output logic [DW-1:0]    host_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_cs_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic [LANES-1:0] mem_be_n,
    output logic [DW-1:0]    mem_dout,
    output logic             mem_dout_en,
    input  logic [DW-1:0]    mem_din
);
    localparam int RD_CLKS = int'(ceil_clks(CYCLE_NS, CLK_PERIOD_NS));
    localparam int WP_CLKS = int'(ceil_clks(WPULSE_NS, CLK_PERIOD_NS));
    localparam int CNT_MAX = (RD_CLKS > WP_CLKS) ? RD_CLKS : WP_CLKS;
    localparam int CW      = $clog2(CNT_MAX + 1);

    acc_state_e       state;
    logic             accept, ld, dec, capture, expired;
    logic [CW-1:0]    ld_val;
    logic [LANES-1:0] mask_q;
    logic             busy;

    sram_lane_fsm #(.RD_CLKS(RD_CLKS), .WP_CLKS(WP_CLKS), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(host_req), .wr(host_wr),
        .mask_any(|host_mask), .expired(expired), .state(state),
        .accept(accept), .ld(ld), .ld_val(ld_val), .dec(dec),
        .capture(capture), .done(host_done)
    );

    sram_wait_ctr #(.W(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
        .dec(dec), .expired(expired)
    );

    sram_lane_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
        .mem_din(mem_din), .addr_q(mem_addr), .wdata_q(mem_dout),
        .mask_q(mask_q), .rdata(host_rdata)
    );

    // Decode the memory strobes from the access state.
    always_comb begin
        busy        = (state != ACC_IDLE);
        mem_cs_n    = !busy;
        mem_oe_n    = !(state == ACC_READ);
        mem_we_n    = !(state == ACC_WRITE);
        mem_dout_en = (state == ACC_WRITE) || (state == ACC_HOLD);
        mem_be_n    = ~(mask_q & {LANES{busy}});
    end
endmodule

// File: rtl/sram_lane_chk.sv
// Protocol checker for sram_lane_ctrl, attached by bind.
// Assumes: it observes the top-level ports only.
module sram_lane_chk #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_req,
    input logic [LANES-1:0] host_mask,
    input logic             host_done,
    input logic [DW-1:0]    host_rdata,
    input logic [AW-1:0]    mem_addr,
    input logic             mem_cs_n,
    input logic             mem_oe_n,
    input logic             mem_we_n,
    input logic [LANES-1:0] mem_be_n,
    input logic [DW-1:0]    mem_dout,
    input logic             mem_dout_en
);
    // R2
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_oe_n && mem_we_n && (&mem_be_n) && !mem_dout_en));

    // R3
    read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && mem_we_n && !(&mem_be_n)));

    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_done |-> $stable(host_rdata));

    // R5
    write_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dout_en));

    // R6
    no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dout_en && !mem_oe_n));

    // R6
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !mem_cs_n) |-> (mem_dout_en && $stable(mem_dout) && $stable(mem_be_n)));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> (mem_cs_n && !mem_dout_en));

    // R8
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n && host_req && (host_mask == '0)) |=> (host_done && mem_cs_n));

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl sram_lane_chk #(.AW(AW), .DW(DW), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_mask(host_mask),
    .host_done(host_done), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en)
);

// File: tb/sram_lane_ctrl_test.sv
// Bench: behavioural SRAM model plus a cycle reference model, compared every cycle.
module sram_lane_ctrl_test;
    localparam int CLKP = 10;
    localparam int CYC  = 25;
    localparam int WPL  = 12;
    localparam int RD_E = (CYC + CLKP - 1) / CLKP;   // R11: 3
    localparam int WP_E = (WPL + CLKP - 1) / CLKP;   // R11: 2

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [15:0] host_addr = '0, host_wdata = '0;
    logic [1:0]  host_mask = '0;
    logic        host_done;
    logic [15:0] host_rdata, mem_addr, mem_dout;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_din = 16'hDEAD;

    int total = 0, bad = 0;
    int oe_cnt = 0, we_cnt = 0, cs_cnt = 0;

    // Reference model state.
    int          r_kind = 0;   // 0 idle, 1 read, 2 write, 3 hold
    int          r_left = 0;
    logic [15:0] r_a = '0, r_d = '0, r_rdata = '0;
    logic [1:0]  r_m = '0;
    logic        r_done = 1'b0;
    logic [15:0] mem [int];

    always #(CLKP/2) clk = ~clk;

    sram_lane_ctrl #(.AW(16), .DW(16), .CLK_PERIOD_NS(CLKP), .CYCLE_NS(CYC), .WPULSE_NS(WPL)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
        .host_done(host_done), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    function automatic logic [15:0] mem_rd(input logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : (a ^ 16'h5A3C);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model step at a clock edge.
    task automatic ref_step;
        logic [15:0] w;
        r_done = 1'b0;
        if (!rst_n) begin
            r_kind = 0; r_a = '0; r_d = '0; r_m = '0; r_rdata = '0;
        end else begin
            case (r_kind)
                0: if (host_req) begin
                       if (host_mask == 2'b00) r_done = 1'b1;
                       else begin
                           r_a = host_addr; r_d = host_wdata; r_m = host_mask;
                           r_kind = host_wr ? 2 : 1;
                           r_left = host_wr ? WP_E : RD_E;
                       end
                   end
                1: begin
                       r_left--;
                       if (r_left == 0) begin
                           w = mem_rd(r_a);
                           r_rdata = {r_m[1] ? w[15:8] : 8'h00, r_m[0] ? w[7:0] : 8'h00};
                           r_done = 1'b1; r_kind = 0;
                       end
                   end
                2: begin
                       r_left--;
                       if (r_left == 0) r_kind = 3;
                   end
                default: begin r_kind = 0; r_done = 1'b1; end
            endcase
        end
    endtask

    // One clock: model edge, compare away from the edge, then run the memory model.
    task automatic tick;
        string tg;
        logic [15:0] w;
        @(posedge clk);
        ref_step();
        @(negedge clk);
        tg = (r_kind == 0) ? "R2" : (r_kind == 1) ? "R3" : (r_kind == 2) ? "R5" : "R6";
        chk(mem_cs_n == (r_kind == 0), tg, 32'(mem_cs_n), 32'(r_kind == 0));
        chk(mem_oe_n == (r_kind != 1), tg, 32'(mem_oe_n), 32'(r_kind != 1));
        chk(mem_we_n == (r_kind != 2), tg, 32'(mem_we_n), 32'(r_kind != 2));
        chk(mem_dout_en == (r_kind >= 2), tg, 32'(mem_dout_en), 32'(r_kind >= 2));
        chk(mem_be_n == ((r_kind == 0) ? 2'b11 : ~r_m), tg, 32'(mem_be_n), 32'((r_kind == 0) ? 2'b11 : ~r_m));
        if (r_kind != 0) chk(mem_addr == r_a, "R10", 32'(mem_addr), 32'(r_a));
        if (r_kind >= 2) chk(mem_dout == r_d, "R5", 32'(mem_dout), 32'(r_d));
        chk(host_done == r_done, "R7", 32'(host_done), 32'(r_done));
        chk(host_rdata == r_rdata, "R4", 32'(host_rdata), 32'(r_rdata));
        if (!mem_oe_n) oe_cnt++;
        if (!mem_we_n) we_cnt++;
        if (!mem_cs_n) cs_cnt++;
        // Memory model: store enabled lanes during the write strobe.
        if (!mem_cs_n && !mem_we_n && mem_dout_en) begin
            w = mem_rd(mem_addr);
            if (!mem_be_n[0]) w[7:0]  = mem_dout[7:0];
            if (!mem_be_n[1]) w[15:8] = mem_dout[15:8];
            mem[int'(mem_addr)] = w;
        end
        if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            w = mem_rd(mem_addr);
            mem_din = {mem_be_n[1] ? 8'hA5 : w[15:8], mem_be_n[0] ? 8'hA5 : w[7:0]};
        end else
            mem_din = 16'hDEAD;
    endtask

    // Issue one request and wait for completion; optional noise on req while busy.
    task automatic op(input bit w, input logic [15:0] a, input logic [15:0] d,
                      input logic [1:0] m, input bit noisy);
        int n;
        oe_cnt = 0; we_cnt = 0; cs_cnt = 0;
        host_req = 1'b1; host_wr = w; host_addr = a; host_wdata = d; host_mask = m;
        tick();
        if (noisy && !host_done) begin
            host_wr = !w; host_addr = ~a; host_wdata = ~d; host_mask = 2'b11;
        end else
            host_req = 1'b0;
        n = 0;
        while (!host_done && n < 20) begin tick(); n++; end
        host_req = 1'b0;
        if (!host_done) chk(1'b0, "R7 watchdog", 32'(n), 32'(0));
    endtask

    initial begin
        logic [15:0] lf;
        // R1: reset state.
        repeat (3) tick();
        chk(mem_cs_n && mem_oe_n && mem_we_n && (mem_be_n == 2'b11), "R1", {mem_cs_n, mem_oe_n, mem_we_n, mem_be_n}, 5'h1F);
        chk(!mem_dout_en && !host_done && host_rdata == 16'h0, "R1", {mem_dout_en, host_done, host_rdata}, 0);
        rst_n = 1'b1;
        tick();
        chk(mem_cs_n && !host_done, "R1", {mem_cs_n, host_done}, 2'b10);

        // R5, R11: full-word write and its pulse length.
        op(1, 16'h0010, 16'h1234, 2'b11, 0);
        chk(we_cnt == WP_E, "R11", we_cnt, WP_E);
        // R3, R4, R11: full-word read.
        op(0, 16'h0010, 16'h0, 2'b11, 0);
        chk(oe_cnt == RD_E, "R11", oe_cnt, RD_E);
        chk(host_rdata == 16'h1234, "R4", host_rdata, 16'h1234);
        // R5: low lane only, then high lane only.
        op(1, 16'h0010, 16'hABCD, 2'b01, 0);
        op(0, 16'h0010, 16'h0, 2'b11, 0);
        chk(host_rdata == 16'h12CD, "R5", host_rdata, 16'h12CD);
        op(1, 16'h0010, 16'h77EE, 2'b10, 0);
        op(0, 16'h0010, 16'h0, 2'b11, 0);
        chk(host_rdata == 16'h77CD, "R5", host_rdata, 16'h77CD);
        // R4: single-lane reads zero the other lane.
        op(0, 16'h0010, 16'h0, 2'b01, 0);
        chk(host_rdata == 16'h00CD, "R4", host_rdata, 16'h00CD);
        op(0, 16'h0010, 16'h0, 2'b10, 0);
        chk(host_rdata == 16'h7700, "R4", host_rdata, 16'h7700);
        // R8: zero mask touches nothing.
        op(1, 16'h0010, 16'hFFFF, 2'b00, 0);
        chk(cs_cnt == 0, "R8", cs_cnt, 0);
        op(0, 16'h0010, 16'h0, 2'b11, 0);
        chk(host_rdata == 16'h77CD, "R8", host_rdata, 16'h77CD);
        // R9: requests during a busy access are ignored.
        op(1, 16'h0020, 16'hC0DE, 2'b11, 1);
        tick();
        chk(mem_cs_n == 1'b1, "R9", mem_cs_n, 1);
        op(0, 16'hFFDF, 16'h0, 2'b11, 0);
        chk(host_rdata == (16'hFFDF ^ 16'h5A3C), "R9", host_rdata, 16'hFFDF ^ 16'h5A3C);
        op(0, 16'h0020, 16'h0, 2'b11, 1);
        chk(host_rdata == 16'hC0DE, "R9", host_rdata, 16'hC0DE);
        // R6: write followed at once by a read.
        op(1, 16'h0030, 16'h5555, 2'b11, 0);
        op(0, 16'h0030, 16'h0, 2'b11, 0);
        chk(host_rdata == 16'h5555, "R6", host_rdata, 16'h5555);
        // Mixed traffic against the reference model.
        lf = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op(lf[0], {12'h004, lf[4:1]}, lf ^ 16'h3C3C, lf[6:5], lf[7]);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLKP * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule